// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block runs the control side of one bus-master DMA command between an IDE drive (hard disk or optical) and a descriptor-driven DMA channel. A start pulse captures the command, the drive type and the position fields. It then loads a count of bytes still owed to the command, clears a progress index, raises its active flag and pulses a kick to the channel.

The channel then hands the sequencer one descriptor chunk at a time as a length. For each chunk the sequencer chooses one outcome. It can ask the channel to wait because the transfer is not active. It can finish the command because no bytes remain. It can close a zero-length descriptor. It can copy a non-block optical payload directly. In the normal case it issues a read, write or trim request carrying the media byte offset and the length. The data path answers a request with done or error, and that answer closes the descriptor, completes the command or reports a DMA fault. Data movement itself lies outside the block.

Top module: `ide_dma_seq`

## Requirements
- R1: While reset is held and after it is released, `active_o` is 0, `status_o` is 8'h00 and every pulse output (`kick_o`, `irq_o`, `err_o`, `desc_end_o`, `wait_o`, `req_valid_o`, `acct_o`, `acct_fail_o`) is 0.
- R2: A start seen with no request outstanding pulses `kick_o` one cycle later and sets `active_o` to 1 and `status_o` to 8'h80. It loads the remaining-byte count with `nsect_i`×512 for a disk (`optical_i`=0) or with `pkt_size_i` for an optical drive, and sets the progress index to 0.
- R3: For a disk, a request's `req_ofs_o` is `sector`×512 plus the progress index, with the sector captured at start.
- R4: For an optical drive, a request's `req_ofs_o` is `lba`×2048 plus the progress index, and the operation is always read (0).
- R5: A chunk that arrives while the transfer is inactive produces a one-cycle `wait_o` and no request.
- R6: The command completes when the remaining count is zero or negative at a chunk, or when a request finishes and leaves the count there. On completion `irq_o` and `desc_end_o` pulse, `active_o` falls and `status_o` becomes 8'h50.
- R7: A zero-length chunk while bytes remain pulses only `desc_end_o`. The command stays active.
- R8: Each normal request takes the full chunk length as `req_len_o`. The remaining count drops by that length and the progress index rises by it. A finished request that still leaves bytes owed pulses only `desc_end_o`.
- R9: An optical command with LBA all ones issues a copy request (op 3) with offset 0 and length equal to the smaller of the remaining count and the chunk length. Its completion ends the command as in R6.
- R10: A data-path error while a request is outstanding pulses `err_o`, `irq_o` and `desc_end_o`, clears `active_o` and sets `status_o` to 8'h41.
- R11: Operation codes on `req_op_o` are 0 read, 1 write, 2 trim and 3 copy. For a disk, `cmd_i` 0 selects read, 1 selects write, and 2 or 3 select trim.
- R12: At completion or error, `acct_o` pulses only for optical commands and disk read or write, never for trim. `acct_fail_o` pulses with it on error.
- R13: While a request is outstanding, chunk and start inputs are ignored and leave no trace on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a DMA command |
| optical_i | input | 1 | Drive is optical (1) or disk (0) |
| cmd_i | input | 2 | Disk command code |
| sector_i | input | SECW | Current disk sector |
| lba_i | input | LBAW | Optical block address |
| nsect_i | input | NSW | Disk sector count |
| pkt_size_i | input | CNTW | Optical packet transfer size in bytes |
| chunk_valid_i | input | 1 | Channel presents a descriptor chunk |
| chunk_len_i | input | CNTW | Chunk length in bytes |
| dp_done_i | input | 1 | Data path finished the request |
| dp_err_i | input | 1 | Data path reports an error |
| kick_o | output | 1 | Pulse to start the channel |
| active_o | output | 1 | DMA transfer active |
| status_o | output | 8 | Drive status byte |
| irq_o | output | 1 | Drive interrupt pulse |
| err_o | output | 1 | DMA error pulse |
| desc_end_o | output | 1 | Current descriptor finished |
| wait_o | output | 1 | Channel must wait for a restart |
| req_valid_o | output | 1 | Request to data path |
| req_op_o | output | 2 | Request operation |
| req_ofs_o | output | OFSW | Media byte offset |
| req_len_o | output | CNTW | Request byte length |
| acct_o | output | 1 | Statistics update pulse |
| acct_fail_o | output | 1 | Statistics update is a failure |

## Verification
The bench builds the block with its default widths: 16-bit sector and LBA, 8-bit sector count and 20-bit byte counts. A 16-bit LBA makes the all-ones non-block value cheap to drive, and the 20-bit count holds a full 255-sector load, so one oversized chunk can drive the remaining count negative. The widths also leave room for disk and optical offsets to be told apart by their 512 and 2048 scaling.

// File: rtl/ide_dma_pkg.sv
// Shared types for the IDE DMA sequencer: request operations,
// sequencer phases and the status byte values it reports.
package ide_dma_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TRIM  = 2'd2,
        OP_COPY  = 2'd3
    } dma_op_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } dma_phase_e;

    localparam logic [7:0] ST_CLEAR = 8'h00;
    localparam logic [7:0] ST_BUSY  = 8'h80;
    localparam logic [7:0] ST_DONE  = 8'h50;
    localparam logic [7:0] ST_FAULT = 8'h41;

endpackage

// File: rtl/ide_dma_counter.sv
// Remaining-byte counter and progress index for one DMA command.
// Assumes load and step are never asserted together; the remaining
// count is signed so an overshooting chunk leaves it negative.
module ide_dma_counter #(
    parameter int CNTW = 20,
    parameter int NSW  = 8,
    localparam int RW  = CNTW + 2,
    localparam int IW  = CNTW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 optical_i,
    input  logic [NSW-1:0]       nsect_i,
    input  logic [CNTW-1:0]      pkt_i,
    input  logic                 step_i,
    input  logic [CNTW-1:0]      step_len_i,
    output logic signed [RW-1:0] rem_o,
    output logic [IW-1:0]        idx_o
);

    logic [RW-1:0] disk_bytes;
    logic [RW-1:0] pkt_bytes;

    // Byte totals for the two drive kinds, widened to the counter.
    always_comb begin
        disk_bytes = {{(RW-NSW-9){1'b0}}, nsect_i, 9'd0};
        pkt_bytes  = {2'b00, pkt_i};
    end

    // Load at start, then consume one chunk per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_o <= '0;
            idx_o <= '0;
        end else if (load_i) begin
            rem_o <= optical_i ? pkt_bytes : disk_bytes;
            idx_o <= '0;
        end else if (step_i) begin
            rem_o <= rem_o - {2'b00, step_len_i};
            idx_o <= idx_o + {1'b0, step_len_i};
        end
    end

    assert_load_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (idx_o == '0));

    assert_load_step_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && step_i));

    assert_step_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (rem_o > 0));

endmodule

// File: rtl/ide_dma_offset.sv
// Media byte offset for the next chunk: sector*512 for a disk or
// lba*2048 for an optical drive, plus the progress index. Also flags
// the non-block optical case (LBA all ones). Purely combinational.
module ide_dma_offset #(
    parameter int SECW = 16,
    parameter int LBAW = 16,
    parameter int IW   = 21,
    parameter int OFSW = 28,
    localparam int DW  = SECW + 9,
    localparam int OW  = LBAW + 11
) (
    input  logic            optical_i,
    input  logic [SECW-1:0] sector_i,
    input  logic [LBAW-1:0] lba_i,
    input  logic [IW-1:0]   idx_i,
    output logic [OFSW-1:0] ofs_o,
    output logic            nonblk_o
);

    logic [OFSW-1:0] disk_base;
    logic [OFSW-1:0] opt_base;
    logic [OFSW-1:0] idx_ext;

    // Scale the drive position and add the bytes already moved.
    always_comb begin
        disk_base = {{(OFSW-DW){1'b0}}, sector_i, 9'd0};
        opt_base  = {{(OFSW-OW){1'b0}}, lba_i, 11'd0};
        idx_ext   = {{(OFSW-IW){1'b0}}, idx_i};
        ofs_o     = (optical_i ? opt_base : disk_base) + idx_ext;
        nonblk_o  = optical_i & (&lba_i);
    end

endmodule

// File: rtl/ide_dma_ctrl.sv
// Command control for the IDE DMA sequencer. Captures the command at
// start, classifies each channel chunk, issues requests and retires
// them on data-path done or error. Assumes the data path answers each
// request exactly once with done or error.
module ide_dma_ctrl
    import ide_dma_pkg::*;
#(
    parameter int SECW = 16,
    parameter int LBAW = 16,
    parameter int CNTW = 20,
    parameter int OFSW = 28,
    localparam int RW  = CNTW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 optical_i,
    input  logic [1:0]           cmd_i,
    input  logic [SECW-1:0]      sector_i,
    input  logic [LBAW-1:0]      lba_i,
    input  logic                 chunk_valid_i,
    input  logic [CNTW-1:0]      chunk_len_i,
    input  logic                 dp_done_i,
    input  logic                 dp_err_i,
    input  logic signed [RW-1:0] rem_i,
    input  logic [OFSW-1:0]      ofs_i,
    input  logic                 nonblk_i,
    output logic                 load_o,
    output logic                 step_o,
    output logic                 opt_q_o,
    output logic [SECW-1:0]      sector_q_o,
    output logic [LBAW-1:0]      lba_q_o,
    output logic                 kick_o,
    output logic                 active_o,
    output logic [7:0]           status_o,
    output logic                 irq_o,
    output logic                 err_o,
    output logic                 desc_end_o,
    output logic                 wait_o,
    output logic                 req_valid_o,
    output logic [1:0]           req_op_o,
    output logic [OFSW-1:0]      req_ofs_o,
    output logic [CNTW-1:0]      req_len_o,
    output logic                 acct_o,
    output logic                 acct_fail_o
);

    dma_phase_e      phase;
    logic [1:0]      cmd_q;
    logic            pend_copy;
    logic            ev_start, ev_chunk, rem_pos, len_zero, issue;
    logic            fin_ok, fin_err, desc_only, wait_ev, counted, retire;
    logic [CNTW-1:0] copy_len;
    dma_op_e         op_sel;

    // Classify this cycle's event and the outcome it leads to.
    always_comb begin
        ev_start  = (phase == PH_IDLE) && start_i;
        ev_chunk  = (phase == PH_IDLE) && !start_i && chunk_valid_i;
        rem_pos   = (rem_i > 0);
        len_zero  = (chunk_len_i == '0);
        issue     = ev_chunk && active_o && rem_pos && !len_zero;
        retire    = (phase == PH_WAIT) && !dp_err_i && dp_done_i;
        fin_err   = (phase == PH_WAIT) && dp_err_i;
        fin_ok    = (ev_chunk && active_o && !rem_pos) ||
                    (retire && (pend_copy || !rem_pos));
        desc_only = (ev_chunk && active_o && rem_pos && len_zero) ||
                    (retire && !pend_copy && rem_pos);
        wait_ev   = ev_chunk && !active_o;
        load_o    = ev_start;
        step_o    = issue && !nonblk_i;
        copy_len  = ($signed({2'b00, chunk_len_i}) < rem_i) ? chunk_len_i
                                                             : rem_i[CNTW-1:0];
        counted   = opt_q_o || !cmd_q[1];
        if (opt_q_o || cmd_q == 2'd0) op_sel = OP_READ;
        else if (cmd_q == 2'd1)       op_sel = OP_WRITE;
        else                          op_sel = OP_TRIM;
    end

    // Phase: a request is outstanding from issue until done or error.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   phase <= PH_IDLE;
        else if (issue)                               phase <= PH_WAIT;
        else if (phase == PH_WAIT && (dp_err_i || dp_done_i)) phase <= PH_IDLE;
    end

    // Capture the command fields when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_q_o    <= 1'b0;
            cmd_q      <= 2'd0;
            sector_q_o <= '0;
            lba_q_o    <= '0;
        end else if (ev_start) begin
            opt_q_o    <= optical_i;
            cmd_q      <= cmd_i;
            sector_q_o <= sector_i;
            lba_q_o    <= lba_i;
        end
    end

    // Active flag and drive status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            status_o <= ST_CLEAR;
        end else if (ev_start) begin
            active_o <= 1'b1;
            status_o <= ST_BUSY;
        end else if (fin_err) begin
            active_o <= 1'b0;
            status_o <= ST_FAULT;
        end else if (fin_ok) begin
            active_o <= 1'b0;
            status_o <= ST_DONE;
        end
    end

    // One-cycle event pulses toward the channel, the host and statistics.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kick_o      <= 1'b0;
            irq_o       <= 1'b0;
            err_o       <= 1'b0;
            desc_end_o  <= 1'b0;
            wait_o      <= 1'b0;
            req_valid_o <= 1'b0;
            acct_o      <= 1'b0;
            acct_fail_o <= 1'b0;
        end else begin
            kick_o      <= ev_start;
            irq_o       <= fin_ok || fin_err;
            err_o       <= fin_err;
            desc_end_o  <= fin_ok || fin_err || desc_only;
            wait_o      <= wait_ev;
            req_valid_o <= issue;
            acct_o      <= (fin_ok || fin_err) && counted;
            acct_fail_o <= fin_err && counted;
        end
    end

    // Request fields, held from issue until the next request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_op_o  <= OP_READ;
            req_ofs_o <= '0;
            req_len_o <= '0;
            pend_copy <= 1'b0;
        end else if (issue) begin
            req_op_o  <= nonblk_i ? OP_COPY : op_sel;
            req_ofs_o <= nonblk_i ? '0 : ofs_i;
            req_len_o <= nonblk_i ? copy_len : chunk_len_i;
            pend_copy <= nonblk_i;
        end
    end

    assert_kick_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |-> (active_o && status_o == ST_BUSY));

    assert_wait_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> (!active_o && !req_valid_o));

    assert_irq_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!active_o && desc_end_o));

    assert_copy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_op_o == OP_COPY) |-> (req_len_o <= $past(chunk_len_i)));

    assert_err_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (irq_o && status_o == ST_FAULT));

    assert_no_trim_acct_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acct_o |-> (opt_q_o || !cmd_q[1]));

    assert_single_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> !req_valid_o);

endmodule

// File: rtl/ide_dma_seq.sv
// Top of the IDE DMA transfer sequencer. Joins the command control,
// the byte counter and the offset calculator. Assumes a single active
// drive and one outstanding data-path request at a time.
module ide_dma_seq #(
    parameter int SECW = 16,
    parameter int LBAW = 16,
    parameter int NSW  = 8,
    parameter int CNTW = 20,
    parameter int OFSW = (((SECW + 9) > (LBAW + 11) ? (SECW + 9) : (LBAW + 11)) > (CNTW + 1)
                          ? ((SECW + 9) > (LBAW + 11) ? (SECW + 9) : (LBAW + 11))
                          : (CNTW + 1)) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            optical_i,
    input  logic [1:0]      cmd_i,
    input  logic [SECW-1:0] sector_i,
    input  logic [LBAW-1:0] lba_i,
    input  logic [NSW-1:0]  nsect_i,
    input  logic [CNTW-1:0] pkt_size_i,
    input  logic            chunk_valid_i,
    input  logic [CNTW-1:0] chunk_len_i,
    input  logic            dp_done_i,
    input  logic            dp_err_i,
    output logic            kick_o,
    output logic            active_o,
    output logic [7:0]      status_o,
    output logic            irq_o,
    output logic            err_o,
    output logic            desc_end_o,
    output logic            wait_o,
    output logic            req_valid_o,
    output logic [1:0]      req_op_o,
    output logic [OFSW-1:0] req_ofs_o,
    output logic [CNTW-1:0] req_len_o,
    output logic            acct_o,
    output logic            acct_fail_o
);

    localparam int RW = CNTW + 2;
    localparam int IW = CNTW + 1;

    logic                 load, step, opt_q, nonblk;
    logic signed [RW-1:0] rem;
    logic [IW-1:0]        idx;
    logic [OFSW-1:0]      ofs;
    logic [SECW-1:0]      sector_q;
    logic [LBAW-1:0]      lba_q;

    ide_dma_counter #(.CNTW(CNTW), .NSW(NSW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .optical_i  (optical_i),
        .nsect_i    (nsect_i),
        .pkt_i      (pkt_size_i),
        .step_i     (step),
        .step_len_i (chunk_len_i),
        .rem_o      (rem),
        .idx_o      (idx)
    );

    ide_dma_offset #(.SECW(SECW), .LBAW(LBAW), .IW(IW), .OFSW(OFSW)) u_ofs (
        .optical_i (opt_q),
        .sector_i  (sector_q),
        .lba_i     (lba_q),
        .idx_i     (idx),
        .ofs_o     (ofs),
        .nonblk_o  (nonblk)
    );

    ide_dma_ctrl #(.SECW(SECW), .LBAW(LBAW), .CNTW(CNTW), .OFSW(OFSW)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .optical_i     (optical_i),
        .cmd_i         (cmd_i),
        .sector_i      (sector_i),
        .lba_i         (lba_i),
        .chunk_valid_i (chunk_valid_i),
        .chunk_len_i   (chunk_len_i),
        .dp_done_i     (dp_done_i),
        .dp_err_i      (dp_err_i),
        .rem_i         (rem),
        .ofs_i         (ofs),
        .nonblk_i      (nonblk),
        .load_o        (load),
        .step_o        (step),
        .opt_q_o       (opt_q),
        .sector_q_o    (sector_q),
        .lba_q_o       (lba_q),
        .kick_o        (kick_o),
        .active_o      (active_o),
        .status_o      (status_o),
        .irq_o         (irq_o),
        .err_o         (err_o),
        .desc_end_o    (desc_end_o),
        .wait_o        (wait_o),
        .req_valid_o   (req_valid_o),
        .req_op_o      (req_op_o),
        .req_ofs_o     (req_ofs_o),
        .req_len_o     (req_len_o),
        .acct_o        (acct_o),
        .acct_fail_o   (acct_fail_o)
    );

endmodule

// File: tb/sim_ide_dma_seq.sv
// Cycle-by-cycle behavioural reference for the IDE DMA sequencer,
// compared against the design after every clock edge.
module sim_ide_dma_seq;

    localparam int OFSW = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, optical_i = 1'b0;
    logic [1:0]  cmd_i = 2'd0;
    logic [15:0] sector_i = '0, lba_i = '0;
    logic [7:0]  nsect_i = '0;
    logic [19:0] pkt_size_i = '0, chunk_len_i = '0;
    logic        chunk_valid_i = 1'b0, dp_done_i = 1'b0, dp_err_i = 1'b0;
    logic        kick_o, active_o, irq_o, err_o, desc_end_o, wait_o;
    logic        req_valid_o, acct_o, acct_fail_o;
    logic [7:0]  status_o;
    logic [1:0]  req_op_o;
    logic [OFSW-1:0] req_ofs_o;
    logic [19:0] req_len_o;

    int vectors = 0;
    int fails = 0;
    bit seen = 0;
    bit done_run = 0;

    ide_dma_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .optical_i(optical_i),
        .cmd_i(cmd_i), .sector_i(sector_i), .lba_i(lba_i), .nsect_i(nsect_i),
        .pkt_size_i(pkt_size_i), .chunk_valid_i(chunk_valid_i),
        .chunk_len_i(chunk_len_i), .dp_done_i(dp_done_i), .dp_err_i(dp_err_i),
        .kick_o(kick_o), .active_o(active_o), .status_o(status_o), .irq_o(irq_o),
        .err_o(err_o), .desc_end_o(desc_end_o), .wait_o(wait_o),
        .req_valid_o(req_valid_o), .req_op_o(req_op_o), .req_ofs_o(req_ofs_o),
        .req_len_o(req_len_o), .acct_o(acct_o), .acct_fail_o(acct_fail_o)
    );

    always #5 clk = ~clk;

    // Reference model state.
    longint m_rem = 0, m_idx = 0, m_sec = 0, m_lba = 0;
    int     m_cmd = 0, m_status = 0;
    bit     m_opt = 0, m_busy = 0, m_copy = 0, m_active = 0, m_inrst = 1;
    bit     e_kick, e_irq, e_err, e_dend, e_wait, e_req, e_acct, e_fail;
    int     e_op = 0;
    longint e_ofs = 0, e_len = 0;

    always @(posedge clk) begin
        bit fin_ok, fin_err, dend, counted;
        fin_ok = 0; fin_err = 0; dend = 0;
        e_kick = 0; e_irq = 0; e_err = 0; e_dend = 0; e_wait = 0;
        e_req = 0; e_acct = 0; e_fail = 0;
        m_inrst = !rst_n;
        if (!rst_n) begin
            m_busy = 0; m_active = 0; m_status = 0; m_rem = 0; m_idx = 0;
            m_copy = 0; m_opt = 0; m_cmd = 0;
        end else if (!m_busy) begin
            if (start_i) begin
                m_opt = optical_i; m_cmd = cmd_i; m_sec = sector_i; m_lba = lba_i;
                m_rem = optical_i ? longint'(pkt_size_i) : longint'(nsect_i) * 512;
                m_idx = 0; m_active = 1; m_status = 'h80; e_kick = 1;
            end else if (chunk_valid_i) begin
                if (!m_active) e_wait = 1;
                else if (m_rem <= 0) fin_ok = 1;
                else if (chunk_len_i == 0) dend = 1;
                else if (m_opt && m_lba == 65535) begin
                    e_req = 1; e_op = 3; e_ofs = 0;
                    e_len = (longint'(chunk_len_i) < m_rem) ? longint'(chunk_len_i) : m_rem;
                    m_copy = 1; m_busy = 1;
                end else begin
                    e_req = 1;
                    e_op = m_opt ? 0 : (m_cmd == 0 ? 0 : (m_cmd == 1 ? 1 : 2));
                    e_ofs = m_opt ? m_lba * 2048 + m_idx : m_sec * 512 + m_idx;
                    e_len = chunk_len_i;
                    m_rem = m_rem - chunk_len_i; m_idx = m_idx + chunk_len_i;
                    m_copy = 0; m_busy = 1;
                end
            end
        end else begin
            if (dp_err_i) begin fin_err = 1; m_busy = 0; end
            else if (dp_done_i) begin
                if (m_copy || m_rem <= 0) fin_ok = 1; else dend = 1;
                m_busy = 0;
            end
        end
        counted = m_opt || m_cmd < 2;
        if (fin_ok)  begin m_active = 0; m_status = 'h50; end
        if (fin_err) begin m_active = 0; m_status = 'h41; e_err = 1; e_fail = counted; end
        e_irq  = fin_ok || fin_err;
        e_dend = fin_ok || fin_err || dend;
        e_acct = (fin_ok || fin_err) && counted;
        seen = 1;
    end

    task automatic chk(string tag, string what, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare every output a little after each edge.
    always @(posedge clk) begin
        #3;
        if (seen) begin
            chk(m_inrst ? "R1" : "R2", "kick",      kick_o,     e_kick);
            chk(m_inrst ? "R1" : "R6", "active",    active_o,   m_active);
            chk(m_inrst ? "R1" : "R6", "status",    status_o,   m_status);
            chk(m_inrst ? "R1" : "R6", "irq",       irq_o,      e_irq);
            chk(m_inrst ? "R1" : "R10", "err",      err_o,      e_err);
            chk(m_inrst ? "R1" : "R7", "desc_end",  desc_end_o, e_dend);
            chk(m_inrst ? "R1" : "R5", "wait",      wait_o,     e_wait);
            chk(m_inrst ? "R1" : "R13", "req_valid", req_valid_o, e_req);
            chk(m_inrst ? "R1" : "R12", "acct",     acct_o,     e_acct);
            chk(m_inrst ? "R1" : "R12", "acct_fail", acct_fail_o, e_fail);
            if (e_req) begin
                chk("R11", "req_op",  req_op_o, e_op);
                chk("R3",  "req_ofs", longint'(req_ofs_o), e_ofs);
                chk("R8",  "req_len", longint'(req_len_o), e_len);
            end
        end
    end

    task automatic gap(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go(bit opt, int cmd, int sec, int lba, int ns, int pkt);
        @(negedge clk);
        optical_i = opt; cmd_i = 2'(cmd); sector_i = 16'(sec); lba_i = 16'(lba);
        nsect_i = 8'(ns); pkt_size_i = 20'(pkt); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic chunk(int len);
        @(negedge clk);
        chunk_valid_i = 1'b1; chunk_len_i = 20'(len);
        @(negedge clk);
        chunk_valid_i = 1'b0;
    endtask

    task automatic dp(bit err);
        @(negedge clk);
        dp_done_i = !err; dp_err_i = err;
        @(negedge clk);
        dp_done_i = 1'b0; dp_err_i = 1'b0;
    endtask

    initial begin
        // R1: reset state
        gap(4);
        rst_n = 1'b1;
        gap(2);
        // R5: chunk before any start
        chunk(512);
        // R2 R3 R7 R8 R11: disk read of two sectors from sector 5
        go(0, 0, 5, 0, 2, 0);
        chunk(512); dp(0);
        chunk(0);
        chunk(512); dp(0);
        // R5: chunk after completion
        chunk(512);
        // R6 R11: disk write, one oversized chunk drives count negative
        go(0, 1, 9, 0, 1, 0);
        chunk(1024); dp(0);
        // R12 R11: trim, no statistics pulse
        go(0, 2, 3, 0, 1, 0);
        chunk(256); gap(2); dp(0);
        chunk(256); dp(0);
        // R4: optical, write code still reads, lba*2048 offset
        go(1, 1, 0, 10, 0, 3000);
        chunk(2048); dp(0);
        chunk(2048); dp(0);
        // R9: non-block optical, copy clamped to remaining
        go(1, 0, 0, 65535, 0, 100);
        chunk(400); dp(0);
        // R9: non-block optical, copy clamped to chunk
        go(1, 0, 0, 65535, 0, 500);
        chunk(64); dp(0);
        // R10 R12: error on a disk read
        go(0, 0, 7, 0, 4, 0);
        chunk(512); dp(1);
        // R10 R12: error on a trim, no statistics pulse
        go(0, 3, 7, 0, 4, 0);
        chunk(512); dp(1);
        // R13: chunk and start ignored while a request is outstanding
        go(0, 0, 20, 0, 2, 0);
        chunk(512);
        chunk(512);
        go(1, 1, 1, 1, 1, 1);
        dp(0);
        chunk(512); dp(0);
        // R6: zero bytes loaded completes at the first chunk
        go(0, 0, 1, 0, 0, 0);
        chunk(512);
        // R2: restart while active reloads count and index
        go(0, 1, 2, 0, 3, 0);
        chunk(512); dp(0);
        go(0, 1, 40, 0, 1, 0);
        chunk(512); dp(0);
        gap(3);
        done_run = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            fails++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule